// File: doc/BRIEF.md
# Multiprocessor-Capable Serial UART

This block is a full-duplex asynchronous serial transmitter and receiver behind a small register bus. A 12-bit divisor sets the bit rate. Software writes the divisor as a high nibble and a low byte. Frames carry a start bit, 8 or 9 data bits sent LSB first, and one stop bit. The transmitter has a single holding register in front of its shift register, so software can queue one character while another is on the line.

The receiver takes 16 samples per bit. It decides each bit by a majority vote taken in the middle of the bit. It rejects start bits that prove to be glitches. It keeps one received character in a data register, together with that character's framing-error and overrun status.

A multiprocessor mode lets several receivers share one line. While the mode bit is set, a receiver drops every frame whose address flag is zero. Software inspects the address character it does accept. When the address matches, software clears the mode bit so that the data frames that follow are delivered.

Top module: `mpuart`

## Requirements
- R1: After reset the TX line is high, the status register reads 0x02 (holding register empty, nothing received), the control register reads 0x00 and the divisor is 0.
- R2: One bit lasts 16·(D+1) clock cycles, where D is the 12-bit divisor. D is formed from the divisor-high register (bits 3:0 give D[11:8]) and the divisor-low register (D[7:0]). A divisor write restarts the bit-rate prescaler.
- R3: A transmitted frame is a low start bit, the data bits LSB first, then a high stop bit. The line idles high between frames.
- R4: A write to the data register fills the holding register and clears the empty flag (status bit 1) on the next cycle. The shift register takes the held character when the line is idle, or otherwise once the stop bit of the current frame has been fully sent. The empty flag is set at that transfer, in the same cycle as the start bit appears.
- R5: While the receiver is idle, a single low sample starts start-bit validation. Each bit is decided by the majority of samples 8, 9 and 10. A start bit whose majority is high is discarded and the receiver returns to idle.
- R6: Control bit 0 selects 9 data bits (1) or 8 data bits (0). Control bit 2 is the 9th bit to transmit. Control bit 3 (read-only) holds the 9th bit of the last accepted character, and reads 0 in 8-bit mode.
- R7: When a character is accepted into the receive data register, the receive-complete flag (status bit 0, output rxc_o) is set. A read of the data register clears it.
- R8: A character that completes while the receive-complete flag is still set is dropped, and the held character is kept. The overrun flag (status bit 3) becomes visible only when the held character is read, and the next data-register read clears it.
- R9: The framing-error flag (status bit 2) belongs to the held character. It is 1 when that character's stop-bit majority was low.
- R10: With control bit 1 set, frames whose address flag is 0 are discarded and leave all receive state unchanged. The address flag is the 9th data bit in 9-bit mode and the stop bit in 8-bit mode. Frames with the flag set are accepted. With the bit cleared, every frame is accepted.
- R11: Register addresses are 0 data, 1 control, 2 status, 3 divisor low, 4 divisor high. Writes to the status register have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (data-register read has side effects) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| txd_o | output | 1 | Serial transmit line |
| rxd_i | input | 1 | Serial receive line (asynchronous) |
| rxc_o | output | 1 | Receive-complete flag |
| dre_o | output | 1 | Transmit holding register empty flag |

## Verification
The empty flag falls one clock after a data write. It rises in the same cycle as the start bit, which is at most one prescaler tick after the write when the line is idle. The bench therefore checks it one cycle after the write and again in the middle of the stop bit, when it must still be low. Transmitted bits are sampled half a bit period after the observed falling edge and then one full bit period apart, which leaves a margin for the partial first tick. A received character reaches the data register about two clocks of synchronizer delay plus ten sample ticks into the stop bit. The bench holds the line idle for two further bit periods before it reads any status, so every receive check falls after that point and before the next frame.

// File: rtl/mpuart_pkg.sv
`timescale 1ns/1ps
package mpuart_pkg;
    localparam int OSR     = 16;
    localparam int OSR_W   = $clog2(OSR);
    localparam int MAXD    = 9;
    localparam int FRAME_W = MAXD + 2;
    localparam int POS_W   = $clog2(FRAME_W + 1);
    localparam int VOTE_A  = 8;
    localparam int VOTE_B  = 9;
    localparam int VOTE_C  = 10;

    typedef enum logic [2:0] {
        A_DATA  = 3'd0,
        A_CTRL  = 3'd1,
        A_STAT  = 3'd2,
        A_BAUDL = 3'd3,
        A_BAUDH = 3'd4
    } reg_addr_e;

    typedef enum logic { RX_IDLE, RX_BUSY } rx_state_e;

    typedef struct packed {
        logic [1:0]       sync;
        rx_state_e        st;
        logic [OSR_W-1:0] smp;
        logic [POS_W-1:0] pos;
        logic [1:0]       vote;
        logic [MAXD-1:0]  sh;
    } rx_st_t;

    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] sh;
        logic [POS_W-1:0]   left;
        logic [OSR_W-1:0]   tc;
        logic [MAXD-1:0]    thr;
        logic               empty;
    } tx_st_t;
endpackage

// File: rtl/mpuart_baud.sv
`timescale 1ns/1ps
module mpuart_baud #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             restart,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == div);
        cnt_d = (restart || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/mpuart_tx.sv
`timescale 1ns/1ps
module mpuart_tx
    import mpuart_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            nine,
    input  logic            wr,
    input  logic [MAXD-1:0] wdata,
    output logic            txd,
    output logic            empty
);
    localparam tx_st_t TX_RST = '{busy: 1'b0, sh: '1, left: '0, tc: '0, thr: '0, empty: 1'b1};

    tx_st_t tx_d, tx_q;
    logic   finishing;

    always_comb begin
        tx_d      = tx_q;
        finishing = tx_q.busy && tick && (tx_q.tc == OSR_W'(OSR - 1)) && (tx_q.left == POS_W'(1));
        if (tx_q.busy && tick) begin
            tx_d.tc = tx_q.tc + 1'b1;
            if (tx_q.tc == OSR_W'(OSR - 1)) begin
                tx_d.sh   = {1'b1, tx_q.sh[FRAME_W-1:1]};
                tx_d.left = tx_q.left - 1'b1;
                if (tx_q.left == POS_W'(1)) tx_d.busy = 1'b0;
            end
        end
        if ((!tx_q.busy || finishing) && !tx_q.empty) begin
            tx_d.busy  = 1'b1;
            tx_d.tc    = '0;
            tx_d.empty = 1'b1;
            if (nine) begin
                tx_d.sh   = {1'b1, tx_q.thr, 1'b0};
                tx_d.left = POS_W'(FRAME_W);
            end else begin
                tx_d.sh   = {2'b11, tx_q.thr[7:0], 1'b0};
                tx_d.left = POS_W'(FRAME_W - 1);
            end
        end
        if (wr) begin
            tx_d.thr   = wdata;
            tx_d.empty = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= TX_RST;
        else        tx_q <= tx_d;
    end

    assign txd   = tx_q.busy ? tx_q.sh[0] : 1'b1;
    assign empty = tx_q.empty;
endmodule

// File: rtl/mpuart_rx.sv
`timescale 1ns/1ps
module mpuart_rx
    import mpuart_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            nine,
    input  logic            rxd,
    output logic            done,
    output logic            stop_bit,
    output logic [MAXD-1:0] dat
);
    localparam rx_st_t RX_RST = '{sync: 2'b11, st: RX_IDLE, smp: '0, pos: '0, vote: '0, sh: '0};

    rx_st_t           rx_d, rx_q;
    logic             line, maj;
    logic [OSR_W-1:0] smp_nx;
    logic [POS_W-1:0] stop_pos;
    logic [POS_W-1:0] bit_idx;

    always_comb begin
        rx_d      = rx_q;
        rx_d.sync = {rx_q.sync[0], rxd};
        line      = rx_q.sync[1];
        done      = 1'b0;
        stop_bit  = 1'b0;
        smp_nx    = rx_q.smp + 1'b1;
        maj       = (rx_q.vote[1] & rx_q.vote[0]) | ((rx_q.vote[1] | rx_q.vote[0]) & line);
        stop_pos  = nine ? POS_W'(MAXD + 1) : POS_W'(MAXD);
        bit_idx   = rx_q.pos - 1'b1;
        if (tick) begin
            case (rx_q.st)
                RX_IDLE: begin
                    if (!line) begin
                        rx_d.st  = RX_BUSY;
                        rx_d.smp = OSR_W'(1);
                        rx_d.pos = '0;
                        rx_d.sh  = '0;
                    end
                end
                default: begin
                    rx_d.smp = smp_nx;
                    if (smp_nx == OSR_W'(VOTE_A) || smp_nx == OSR_W'(VOTE_B))
                        rx_d.vote = {rx_q.vote[0], line};
                    if (smp_nx == OSR_W'(VOTE_C)) begin
                        if (rx_q.pos == '0) begin
                            if (maj) rx_d.st = RX_IDLE;
                        end else if (rx_q.pos == stop_pos) begin
                            rx_d.st  = RX_IDLE;
                            done     = 1'b1;
                            stop_bit = maj;
                        end else begin
                            rx_d.sh[bit_idx] = maj;
                        end
                    end
                    if (rx_q.smp == OSR_W'(OSR - 1)) rx_d.pos = rx_q.pos + 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= RX_RST;
        else        rx_q <= rx_d;
    end

    assign dat = rx_q.sh;
endmodule

// File: rtl/mpuart.sv
`timescale 1ns/1ps
module mpuart
    import mpuart_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       txd_o,
    input  logic       rxd_i,
    output logic       rxc_o,
    output logic       dre_o
);
    localparam int HI_W = DIV_W - 8;

    typedef struct packed {
        logic             nine;
        logic             mp;
        logic             txb8;
        logic             rxb8;
        logic             rxc;
        logic             fe;
        logic             ovr_vis;
        logic             ovr_pend;
        logic [7:0]       rdr;
        logic [DIV_W-1:0] div;
    } regs_t;

    regs_t           r_d, r_q;
    logic            tick, restart, wr_data, rd_data, rxc_eff;
    logic            rx_done, rx_stop, addr_flag, rx_drop;
    logic [MAXD-1:0] rx_dat;
    logic            ovr_flag, fe_flag;

    mpuart_baud #(.DIV_W(DIV_W)) baud_i (
        .clk(clk), .rst_n(rst_n), .div(r_q.div), .restart(restart), .tick(tick)
    );

    mpuart_tx tx_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .nine(r_q.nine), .wr(wr_data),
        .wdata({r_q.txb8, wdata}), .txd(txd_o), .empty(dre_o)
    );

    mpuart_rx rx_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .nine(r_q.nine), .rxd(rxd_i),
        .done(rx_done), .stop_bit(rx_stop), .dat(rx_dat)
    );

    always_comb begin
        r_d       = r_q;
        wr_data   = wr_en && (addr == A_DATA);
        rd_data   = rd_en && (addr == A_DATA);
        restart   = wr_en && (addr == A_BAUDL || addr == A_BAUDH);
        addr_flag = r_q.nine ? rx_dat[MAXD-1] : rx_stop;
        rx_drop   = rx_done && r_q.mp && !addr_flag;
        rxc_eff   = r_q.rxc;

        if (wr_en) begin
            case (addr)
                A_CTRL: begin
                    r_d.nine = wdata[0];
                    r_d.mp   = wdata[1];
                    r_d.txb8 = wdata[2];
                end
                A_BAUDL: r_d.div[7:0]       = wdata;
                A_BAUDH: r_d.div[DIV_W-1:8] = wdata[HI_W-1:0];
                default: ;
            endcase
        end

        if (rd_data) begin
            r_d.rxc      = 1'b0;
            r_d.ovr_vis  = r_q.ovr_pend;
            r_d.ovr_pend = 1'b0;
            rxc_eff      = 1'b0;
        end

        if (rx_done && !rx_drop) begin
            if (rxc_eff) begin
                r_d.ovr_pend = 1'b1;
            end else begin
                r_d.rdr  = rx_dat[7:0];
                r_d.rxb8 = r_q.nine & rx_dat[MAXD-1];
                r_d.fe   = !rx_stop;
                r_d.rxc  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ovr_flag = r_q.ovr_vis;
    assign fe_flag  = r_q.fe;
    assign rxc_o    = r_q.rxc;

    always_comb begin
        case (addr)
            A_DATA:  rdata = r_q.rdr;
            A_CTRL:  rdata = {4'b0, r_q.rxb8, r_q.txb8, r_q.mp, r_q.nine};
            A_STAT:  rdata = {4'b0, ovr_flag, fe_flag, dre_o, r_q.rxc};
            A_BAUDL: rdata = r_q.div[7:0];
            A_BAUDH: rdata = 8'(r_q.div >> 8);
            default: rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/mpuart_chk.sv
`timescale 1ns/1ps
module mpuart_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic [2:0] addr,
    input logic       rxc,
    input logic       dre,
    input logic       txd,
    input logic       rx_done,
    input logic       rx_drop,
    input logic       ovr,
    input logic       fe
);
    logic data_rd, data_wr;
    assign data_rd = rd_en && (addr == 3'd0);
    assign data_wr = wr_en && (addr == 3'd0);

    a_r7_read_clears_rxc: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !rx_done) |=> !rxc);

    a_r7_rxc_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rxc) |-> $past(rx_done));

    a_r4_write_fills_holding: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> !dre);

    a_r4_transfer_starts_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dre) |-> !txd);

    a_r8_ovr_shown_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(data_rd));

    a_r9_fe_tracks_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fe) |-> $past(rx_done));

    a_r10_drop_keeps_rxc: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_drop && !data_rd) |=> $stable(rxc));
endmodule

bind mpuart mpuart_chk chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .rxc(rxc_o), .dre(dre_o), .txd(txd_o), .rx_done(rx_done), .rx_drop(rx_drop),
    .ovr(ovr_flag), .fe(fe_flag)
);

// File: tb/mpuart_tb_top.sv
`timescale 1ns/1ps
module mpuart_tb_top;
    localparam int CLK_NS = 10;
    localparam int DIV    = 3;
    localparam int BP     = 16 * (DIV + 1);
    localparam int NVEC   = 8;
    // vector: [11] nine-bit mode, [10] stop bit level, [8:0] data
    localparam logic [11:0] RXV [NVEC] = '{
        12'h455, 12'h4A3, 12'h07E, 12'h400,
        12'hDC4, 12'h901, 12'hC3E, 12'h4FF
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       txd_o, rxc_o, dre_o;
    logic       rxd_i = 1'b1;
    int         n_chk = 0, n_fail = 0;

    always #(CLK_NS/2) clk = ~clk;

    mpuart dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .txd_o(txd_o), .rxd_i(rxd_i),
        .rxc_o(rxc_o), .dre_o(dre_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic send_rx(input logic nine, input logic [8:0] d, input logic stop);
        rxd_i = 1'b0;
        repeat (BP) @(negedge clk);
        for (int i = 0; i < (nine ? 9 : 8); i++) begin
            rxd_i = d[i];
            repeat (BP) @(negedge clk);
        end
        rxd_i = stop;
        repeat (BP) @(negedge clk);
        rxd_i = 1'b1;
        repeat (2 * BP) @(negedge clk);
    endtask

    task automatic get_tx(input int nb, output logic [10:0] bits);
        int t = 0;
        bits = '0;
        while (txd_o !== 1'b0 && t < 40 * BP) begin
            @(negedge clk);
            t++;
        end
        repeat (BP / 2) @(negedge clk);
        bits[0] = txd_o;
        for (int i = 1; i < nb + 2; i++) begin
            repeat (BP) @(negedge clk);
            bits[i] = txd_o;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired (run hung) act=%0d exp=%0d", n_chk, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0]  v;
        logic [10:0] b1, b2;
        logic [11:0] vec;
        int          len;

        repeat (5) @(negedge clk);
        #1;
        // R1 reset state
        chk("R1 txd idle", 16'(txd_o), 16'h1);
        chk("R1 rxc", 16'(rxc_o), 16'h0);
        chk("R1 dre", 16'(dre_o), 16'h1);
        rst_n = 1'b1;
        rd_reg(3'd2, v); chk("R1 status", 16'(v), 16'h02);
        rd_reg(3'd1, v); chk("R1 control", 16'(v), 16'h00);
        rd_reg(3'd3, v); chk("R1 divisor", 16'(v), 16'h00);

        wr_reg(3'd3, 8'(DIV));
        wr_reg(3'd4, 8'h00);
        // R11 status writes are ignored
        wr_reg(3'd2, 8'hFF);
        rd_reg(3'd2, v); chk("R11 status write ignored", 16'(v), 16'h02);

        // table walk over receive frames (R6 R7 R9)
        for (int k = 0; k < NVEC; k++) begin
            vec = RXV[k];
            wr_reg(3'd1, {7'b0, vec[11]});
            send_rx(vec[11], vec[8:0], vec[10]);
            rd_reg(3'd2, v);
            chk("R7 R9 status after frame", 16'(v), 16'({5'b0, ~vec[10], 2'b11}));
            rd_reg(3'd1, v);
            chk("R6 received ninth bit", 16'(v), 16'({4'b0, vec[11] & vec[8], 2'b0, vec[11]}));
            rd_reg(3'd0, v);
            chk("R6 received data", 16'(v), 16'(vec[7:0]));
            rd_reg(3'd2, v);
            chk("R7 read clears rxc", 16'(v), 16'({5'b0, ~vec[10], 2'b10}));
        end

        // R5 short low pulse is rejected as a glitch
        rxd_i = 1'b0;
        repeat (3 * (DIV + 1)) @(negedge clk);
        rxd_i = 1'b1;
        repeat (3 * BP) @(negedge clk);
        rd_reg(3'd2, v); chk("R5 glitch rejected", 16'(v), 16'h02);
        send_rx(1'b0, 9'h0C9, 1'b1);
        rd_reg(3'd0, v); chk("R5 frame after glitch", 16'(v), 16'h00C9);

        // R8 overrun buffered with held data
        send_rx(1'b0, 9'h012, 1'b1);
        send_rx(1'b0, 9'h034, 1'b1);
        rd_reg(3'd2, v); chk("R8 ovr hidden before read", 16'(v), 16'h03);
        rd_reg(3'd0, v); chk("R8 held data kept", 16'(v), 16'h12);
        rd_reg(3'd2, v); chk("R8 ovr visible after read", 16'(v), 16'h0A);
        rd_reg(3'd0, v);
        rd_reg(3'd2, v); chk("R8 ovr cleared by next read", 16'(v), 16'h02);

        // R10 multiprocessor filtering
        wr_reg(3'd1, 8'h03);
        send_rx(1'b1, 9'h077, 1'b1);
        rd_reg(3'd2, v); chk("R10 data frame dropped", 16'(v), 16'h02);
        send_rx(1'b1, 9'h15A, 1'b1);
        rd_reg(3'd2, v); chk("R10 address frame accepted", 16'(v), 16'h03);
        rd_reg(3'd1, v); chk("R10 address flag", 16'(v), 16'h0B);
        rd_reg(3'd0, v); chk("R10 address value", 16'(v), 16'h5A);
        wr_reg(3'd1, 8'h01);
        send_rx(1'b1, 9'h033, 1'b1);
        rd_reg(3'd2, v); chk("R10 data accepted after clear", 16'(v), 16'h03);
        rd_reg(3'd0, v); chk("R10 data value", 16'(v), 16'h33);

        // R3 8-bit transmit
        wr_reg(3'd1, 8'h00);
        wr_reg(3'd0, 8'hA5);
        get_tx(8, b1);
        chk("R3 8-bit frame", 16'(b1[9:0]), 16'({1'b1, 8'hA5, 1'b0}));
        repeat (BP) @(negedge clk);

        // R6 9-bit transmit with ninth bit from control
        wr_reg(3'd1, 8'h05);
        wr_reg(3'd0, 8'h3C);
        get_tx(9, b1);
        chk("R6 9-bit frame", 16'(b1), 16'({2'b11, 8'h3C, 1'b0}));
        repeat (BP) @(negedge clk);

        // R4 holding register behind the shift register
        wr_reg(3'd1, 8'h00);
        wr_reg(3'd0, 8'h11);
        wr_reg(3'd0, 8'h22);
        #1 chk("R4 holding full", 16'(dre_o), 16'h0);
        get_tx(8, b1);
        chk("R4 still held during stop bit", 16'(dre_o), 16'h0);
        get_tx(8, b2);
        chk("R4 empty after transfer", 16'(dre_o), 16'h1);
        chk("R4 first frame", 16'(b1[9:0]), 16'({1'b1, 8'h11, 1'b0}));
        chk("R4 second frame", 16'(b2[9:0]), 16'({1'b1, 8'h22, 1'b0}));
        repeat (BP) @(negedge clk);

        // R2 R11 split divisor sets bit length 16*(256+1)
        wr_reg(3'd4, 8'h01);
        wr_reg(3'd3, 8'h00);
        wr_reg(3'd0, 8'h01);
        len = 0;
        while (txd_o !== 1'b0 && len < 20000) begin @(negedge clk); len++; end
        len = 0;
        while (txd_o === 1'b0 && len < 20000) begin @(negedge clk); len++; end
        chk("R2 R11 start bit length in range",
            16'(len > 15 * 257 && len <= 16 * 257 + 1), 16'h1);
        if (!(len > 15 * 257 && len <= 16 * 257 + 1))
            $display("  start bit length was %0d clocks", len);
        repeat (10 * 16 * 257) @(negedge clk);
        chk("R3 line idle after frame", 16'(txd_o), 16'h1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule